// File: doc/BRIEF.md
# Windowed Watchdog Counter

A single watchdog channel. A prescaler splits the clock into ticks, and each tick takes one off a down-counter. The counter is reloaded from a programmable timeout value in three cases: when the channel is switched on, when a valid kick arrives, and when the count expires. On expiry the block raises a one-cycle timeout event. Software is expected to kick the channel before that happens.

When windowed operation is compiled in, a kick counts only once the counter has fallen to or below a programmable window threshold. A kick that arrives before that point is too early. It raises a one-cycle violation event and leaves the count running. This catches code that runs away and kicks too often.

When the lock feature is compiled in, a sticky lock can be raised. Once it is set, the configuration is frozen and the channel cannot be switched off. Only the synchronous reset clears it. The event pulses go to whatever interrupt or reset logic surrounds the block.

Top module: `wdog_core`

## Requirements
- R1: While `rst` is high at a clock edge, the block resets. After that edge the prescaler and timeout registers read all ones, the window register reads 0, and `enabled`, `locked`, `in_window`, `timeout_evt` and `violation_evt` are all 0.
- R2: The enable is accepted at some clock edge E by a write with `en_wr`=1 and `en_wdata`=1 while the channel is off. With prescaler value P and timeout value T, `timeout_evt` is then high for exactly the cycle that follows edge E+(T+1)(P+1).
- R3: After a timeout, the counter reloads by itself, and further one-cycle timeout pulses follow every (T+1)(P+1) cycles while the channel stays on.
- R4: A kick accepted at edge K reloads both the prescaler and the down-counter. With no further kick, the next timeout pulse follows edge K+(T+1)(P+1). With windowed operation, a kick is accepted only when counter <= window value.
- R5: With windowed operation, a kick while on and with counter > window value does not reload the counter. It raises `violation_evt` for exactly the one cycle after that edge.
- R6: `in_window` is high only when windowed operation is built in, the channel is on, and counter <= window value.
- R7: Without windowed operation, every kick while on is accepted. `violation_evt` and `in_window` stay 0, and window writes are dropped, so the window register reads 0.
- R8: A kick while the channel is off changes nothing and raises no event.
- R9: With the lock feature, `lock_req` sets `locked`. Once it is set, it stays set until reset. While it is set, writes to the prescaler, timeout and window registers are dropped, and a disable request leaves `enabled` at 1.
- R10: Without the lock feature, `locked` reads 0, `lock_req` has no effect, and disable requests and configuration writes always take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pre_wr | input | 1 | Prescaler write strobe |
| pre_wdata | input | PRE_W | Prescaler write value (tick every value+1 cycles) |
| tmo_wr | input | 1 | Timeout write strobe |
| tmo_wdata | input | CNT_W | Timeout reload write value |
| win_wr | input | 1 | Window threshold write strobe |
| win_wdata | input | CNT_W | Window threshold write value |
| en_wr | input | 1 | Enable write strobe |
| en_wdata | input | 1 | 1 switches the channel on, 0 requests it off |
| lock_req | input | 1 | Sets the sticky lock |
| kick | input | 1 | Kick strobe |
| pre_q | output | PRE_W | Current prescaler value |
| tmo_q | output | CNT_W | Current timeout value |
| win_q | output | CNT_W | Current window threshold (0 without windowed operation) |
| enabled | output | 1 | Channel is on |
| locked | output | 1 | Lock is set |
| in_window | output | 1 | Counter is inside the kick window |
| timeout_evt | output | 1 | One-cycle timeout pulse |
| violation_evt | output | 1 | One-cycle early-kick pulse |

## Verification
The hardest case to reach is telling an early kick that was wrongly taken as a reload apart from one that was correctly refused. The counter cannot be seen at the ports. The bench therefore kicks too early first, and then kicks again in a cycle chosen so that the second kick would itself be early if the first one had reloaded the count. The timeout edge that follows then confirms the reload point. The reload of the prescaler on a kick is shown the same way. A kick is placed one edge before a tick that would otherwise be due, and the bench checks that the timeout moves to where only a full fresh tick period puts it.

// File: rtl/wdog_core.sv
module wdog_core #(
  parameter int CNT_W    = 32,
  parameter int PRE_W    = 16,
  parameter bit WINDOWED = 1'b1,
  parameter bit LOCKABLE = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pre_wr,
  input  logic [PRE_W-1:0] pre_wdata,
  input  logic             tmo_wr,
  input  logic [CNT_W-1:0] tmo_wdata,
  input  logic             win_wr,
  input  logic [CNT_W-1:0] win_wdata,
  input  logic             en_wr,
  input  logic             en_wdata,
  input  logic             lock_req,
  input  logic             kick,
  output logic [PRE_W-1:0] pre_q,
  output logic [CNT_W-1:0] tmo_q,
  output logic [CNT_W-1:0] win_q,
  output logic             enabled,
  output logic             locked,
  output logic             in_window,
  output logic             timeout_evt,
  output logic             violation_evt
);

  logic [PRE_W-1:0] pcnt;
  logic [CNT_W-1:0] cnt;
  logic             en_q, lock_q;
  logic             tick, below, kick_ok, kick_bad, start;

  assign tick     = en_q && (pcnt == '0);
  assign below    = (cnt <= win_q);
  assign kick_ok  = en_q && kick && (!WINDOWED || below);
  assign kick_bad = en_q && kick && WINDOWED && !below;
  assign start    = en_wr && en_wdata && !en_q;

  assign enabled   = en_q;
  assign locked    = lock_q;
  assign in_window = WINDOWED && en_q && below;

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_q <= '1;
      tmo_q <= '1;
    end else if (!lock_q) begin
      if (pre_wr) pre_q <= pre_wdata;
      if (tmo_wr) tmo_q <= tmo_wdata;
    end
  end

  generate
    if (WINDOWED) begin : g_win
      always_ff @(posedge clk) begin
        if (rst)                  win_q <= '0;
        else if (win_wr && !lock_q) win_q <= win_wdata;
      end
    end else begin : g_nowin
      assign win_q = '0;
    end

    if (LOCKABLE) begin : g_lock
      always_ff @(posedge clk) begin
        if (rst) lock_q <= 1'b0;
        else     lock_q <= lock_q | lock_req;
      end
    end else begin : g_nolock
      assign lock_q = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)                          en_q <= 1'b0;
    else if (en_wr && en_wdata)       en_q <= 1'b1;
    else if (en_wr && !lock_q)        en_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pcnt          <= '0;
      cnt           <= '0;
      timeout_evt   <= 1'b0;
      violation_evt <= 1'b0;
    end else begin
      timeout_evt   <= tick && (cnt == '0) && !kick_ok;
      violation_evt <= kick_bad;
      if (start || kick_ok) begin
        pcnt <= pre_q;
        cnt  <= tmo_q;
      end else if (tick) begin
        pcnt <= pre_q;
        cnt  <= (cnt == '0) ? tmo_q : cnt - CNT_W'(1);
      end else if (en_q) begin
        pcnt <= pcnt - PRE_W'(1);
      end
    end
  end

  a_r9_lock_sticky: assert property (@(posedge clk) disable iff (rst)
    lock_q |=> lock_q);
  a_r9_no_disable: assert property (@(posedge clk) disable iff (rst)
    (lock_q && en_q) |=> en_q);
  a_r9_cfg_frozen: assert property (@(posedge clk) disable iff (rst)
    lock_q |=> ($stable(pre_q) && $stable(tmo_q) && $stable(win_q)));
  a_r5_viol_from_kick: assert property (@(posedge clk) disable iff (rst)
    violation_evt |-> $past(kick && en_q));
  a_r2_timeout_when_on: assert property (@(posedge clk) disable iff (rst)
    timeout_evt |-> $past(en_q));
  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    (!en_q && !en_wr) |=> (!timeout_evt && !violation_evt));

endmodule

// File: tb/tb_wdog_core.sv
module tb_wdog_core;
  localparam int CW = 8;
  localparam int PW = 4;
  localparam int NV = 6;
  // {prescaler, timeout, expected latency}
  localparam logic [19:0] VEC [NV] = '{
    {4'd0, 8'd0, 8'd1}, {4'd1, 8'd3, 8'd8}, {4'd2, 8'd2, 8'd9},
    {4'd3, 8'd1, 8'd8}, {4'd0, 8'd5, 8'd6}, {4'd4, 8'd0, 8'd5}};

  logic clk = 0, rst = 1;
  logic pre_wr = 0, tmo_wr = 0, win_wr = 0, en_wr = 0, en_wdata = 0, lock_req = 0, kick = 0;
  logic [PW-1:0] pre_wdata = '0;
  logic [CW-1:0] tmo_wdata = '0, win_wdata = '0;
  logic [PW-1:0] a_pre, b_pre;
  logic [CW-1:0] a_tmo, a_win, b_tmo, b_win;
  logic a_en, a_lk, a_iw, a_to, a_vi, b_en, b_lk, b_iw, b_to, b_vi;
  int nchk = 0, nfail = 0, k = 0;
  bit done = 0;

  always #5 clk = ~clk;

  wdog_core #(.CNT_W(CW), .PRE_W(PW), .WINDOWED(1'b1), .LOCKABLE(1'b1)) dut (
    .clk, .rst, .pre_wr, .pre_wdata, .tmo_wr, .tmo_wdata, .win_wr, .win_wdata,
    .en_wr, .en_wdata, .lock_req, .kick, .pre_q(a_pre), .tmo_q(a_tmo), .win_q(a_win),
    .enabled(a_en), .locked(a_lk), .in_window(a_iw), .timeout_evt(a_to), .violation_evt(a_vi));

  wdog_core #(.CNT_W(CW), .PRE_W(PW), .WINDOWED(1'b0), .LOCKABLE(1'b0)) dut_plain (
    .clk, .rst, .pre_wr, .pre_wdata, .tmo_wr, .tmo_wdata, .win_wr, .win_wdata,
    .en_wr, .en_wdata, .lock_req, .kick, .pre_q(b_pre), .tmo_q(b_tmo), .win_q(b_win),
    .enabled(b_en), .locked(b_lk), .in_window(b_iw), .timeout_evt(b_to), .violation_evt(b_vi));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s k=%0d actual=%0d expected=%0d", req, k, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    k++;
  endtask

  task automatic start();
    en_wr = 1; en_wdata = 1;
    @(negedge clk);
    en_wr = 0;
    k = 0;
  endtask

  task automatic cfg(int p, int t, int w);
    pre_wr = 1; tmo_wr = 1; win_wr = 1;
    pre_wdata = PW'(p); tmo_wdata = CW'(t); win_wdata = CW'(w);
    step();
    pre_wr = 0; tmo_wr = 0; win_wr = 0;
  endtask

  task automatic stop();
    en_wr = 1; en_wdata = 0;
    step();
    en_wr = 0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst = 0;
    // R1 reset state
    chk("R1 pre", a_pre, 32'hF);   chk("R1 tmo", a_tmo, 32'hFF);
    chk("R1 win", a_win, 0);       chk("R1 en", a_en, 0);
    chk("R1 lock", a_lk, 0);       chk("R1 inwin", a_iw, 0);
    chk("R1 to", a_to, 0);         chk("R1 vi", a_vi, 0);

    // R2 R3 vector table: latency and auto reload on both variants
    for (int v = 0; v < NV; v++) begin
      int lat;
      lat = int'(VEC[v][7:0]);
      cfg(int'(VEC[v][19:16]), int'(VEC[v][15:8]), 0);
      start();
      for (int i = 1; i <= 2 * lat; i++) begin
        step();
        chk("R2/R3 windowed", a_to, (k == lat || k == 2 * lat));
        chk("R2/R3 plain", b_to, (k == lat || k == 2 * lat));
      end
      stop();
    end

    // R5 R6 R4: early kick refused, in-window kick reloads
    cfg(0, 10, 4);
    chk("R7 win reads 0", b_win, 0);
    start();
    step(); step();
    kick = 1; step(); kick = 0;                 // k=3
    chk("R5 early kick violation", a_vi, 1);
    chk("R7 plain no violation", b_vi, 0);
    chk("R6 outside window", a_iw, 0);
    step();                                     // k=4
    chk("R5 pulse one cycle", a_vi, 0);
    step();                                     // k=5
    chk("R6 cnt 5 above window", a_iw, 0);
    step();                                     // k=6
    chk("R6 cnt 4 in window", a_iw, 1);
    chk("R7 plain in_window", b_iw, 0);
    step();                                     // k=7
    kick = 1; step(); kick = 0;                 // k=8
    chk("R5 early kick did not reload", a_vi, 0);
    chk("R4 reload leaves window", a_iw, 0);
    while (k < 18) begin
      step();
      chk("R4 no early timeout", a_to, 0);
    end
    step();                                     // k=19
    chk("R4 timeout after kick", a_to, 1);
    step();                                     // k=20
    chk("R3 pulse one cycle", a_to, 0);

    // R8 kick while disabled (counter above window)
    stop();
    kick = 1; step(); kick = 0;
    chk("R8 no violation when off", a_vi, 0);
    chk("R8 no timeout when off", a_to, 0);
    chk("R8 plain no timeout", b_to, 0);
    chk("R8 off", a_en, 0);

    // R4 R7 kick reloads prescaler too
    cfg(2, 1, 255);
    start();
    while (k < 4) step();
    kick = 1; step(); kick = 0;                 // k=5
    step();                                     // k=6
    chk("R4 prescaler reload", a_to, 0);
    chk("R7 plain kick reload", b_to, 0);
    while (k < 10) step();
    chk("R4 before timeout", a_to, 0);
    step();                                     // k=11
    chk("R4 timeout windowed", a_to, 1);
    chk("R7 timeout plain", b_to, 1);

    // R9 R10 lock
    lock_req = 1; step(); lock_req = 0;
    chk("R9 locked", a_lk, 1);
    chk("R10 no lock", b_lk, 0);
    pre_wr = 1; tmo_wr = 1; win_wr = 1;
    pre_wdata = 4'd7; tmo_wdata = 8'd20; win_wdata = 8'd9;
    en_wr = 1; en_wdata = 0;
    step();
    pre_wr = 0; tmo_wr = 0; win_wr = 0; en_wr = 0;
    chk("R9 pre frozen", a_pre, 2);
    chk("R9 tmo frozen", a_tmo, 1);
    chk("R9 win frozen", a_win, 255);
    chk("R9 disable blocked", a_en, 1);
    chk("R10 plain disable", b_en, 0);
    chk("R10 plain pre write", b_pre, 7);
    chk("R10 plain tmo write", b_tmo, 20);
    step(); step();
    chk("R9 lock sticky", a_lk, 1);

    // R1 R9 reset clears lock
    rst = 1; step(); rst = 0;
    chk("R9 reset clears lock", a_lk, 0);
    chk("R1 reset off", a_en, 0);
    chk("R1 reset pre", a_pre, 32'hF);
    chk("R1 reset win", a_win, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule